// File: doc/BRIEF.md
# Set-Associative Replacement Victim Selector

This block holds the replacement bookkeeping for every set of a set-associative cache. When the cache asks which way to overwrite in a given set, the block answers with a way index. The surrounding cache controller keeps the tags and moves the data. It reports two kinds of event to this block: each access to a (set, way) pair, and each line it throws out.

The policy is fixed at elaboration by a parameter. There are three choices:
- **Least-frequently-used** keeps a saturating use count per way. The count is cleared when the line is evicted.
- **Least-recently-used** stores the value of a free-running cycle stamp each time a way is touched.
- **Random** draws the victim from a linear-feedback shift register.

For both counting policies, the victim is the way with the smallest stored value. When values are equal, the lowest way index wins. The stored values are deliberately left out of reset. The controller gives each line a defined value the first time it fills it.

Top module: `repl_victim_sel`

## Requirements
- R1: `victim_valid_o` is high in exactly the cycle after each cycle in which `req_valid_i` is high, and low otherwise. It is low after reset.
- R2: A victim answer reflects the replacement state as it was before any access or eviction presented in the same cycle as the request.
- R3: Under LFU (`POLICY = REPL_LFU`), an access adds one to the count of the addressed (set, way). The count saturates at 2^CNT_W-1.
- R4: Under LFU, an eviction clears the count of the addressed (set, way) to zero. An eviction and an access to the same entry in one cycle leave a count of 1.
- R5: Under LRU (`POLICY = REPL_LRU`), an access stores the current stamp in the addressed (set, way). The stamp is the number of clock edges since reset was released, starting at 0. Eviction notices have no effect.
- R6: Under LFU and LRU, the victim is the way of the requested set with the smallest stored value. A tie goes to the lowest way index.
- R7: Under random policy (`POLICY = REPL_RANDOM`), a 16-bit register is loaded with `SEED` (default 16'hACE1) at reset. It shifts left once per request, with the XOR of bits 15, 13, 12 and 10 entering bit 0. The victim is the register value before the shift, modulo `NUM_WAYS`.
- R8: Reset clears only the output register, the stamp counter and the random register. Stored counts and stamps survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_valid_i | input | 1 | Access to a way is reported this cycle |
| upd_set_i | input | $clog2(NUM_SETS) | Set of the access |
| upd_way_i | input | $clog2(NUM_WAYS) | Way of the access |
| evict_valid_i | input | 1 | Eviction is reported this cycle |
| evict_set_i | input | $clog2(NUM_SETS) | Set of the evicted line |
| evict_way_i | input | $clog2(NUM_WAYS) | Way of the evicted line |
| req_valid_i | input | 1 | Victim requested this cycle |
| req_set_i | input | $clog2(NUM_SETS) | Set for which a victim is wanted |
| victim_valid_o | output | 1 | Victim answer valid |
| victim_way_o | output | $clog2(NUM_WAYS) | Chosen victim way |

## Verification
Each answer is due exactly one clock edge after its request. It is computed from the state before that edge. Accesses and evictions take effect at that same edge and show up only in later answers. The bench drives inputs on the falling edge and computes its expected answers from its own model before applying that cycle's updates. It then samples the outputs on the next falling edge. The LRU stamp model counts edges from the first edge after reset release, so the stamp recorded by each access is known exactly.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    REPL_RANDOM = 2'd0,
    REPL_LRU    = 2'd1,
    REPL_LFU    = 2'd2
  } repl_policy_e;
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb = ^(lfsr_q & TAPS[LFSR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lfsr_q <= SEED[LFSR_W-1:0];
    else if (advance_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  assign state_o = lfsr_q;

  // R7: a maximal-length register never reaches the all-zero lock state
  assert_lfsr_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  assert_lfsr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(lfsr_q));
endmodule

// File: rtl/repl_lfu_array.sv
module repl_lfu_array #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               upd_valid_i,
  input  logic [SET_W-1:0]                   upd_set_i,
  input  logic [WAY_W-1:0]                   upd_way_i,
  input  logic                               evict_valid_i,
  input  logic [SET_W-1:0]                   evict_set_i,
  input  logic [WAY_W-1:0]                   evict_way_i,
  input  logic [SET_W-1:0]                   rd_set_i,
  output logic [NUM_WAYS-1:0][CNT_W-1:0]     rd_vals_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_SETS][NUM_WAYS];
  logic [CNT_W-1:0] cur_cnt;
  logic             same_entry;

  assign cur_cnt    = cnt_q[upd_set_i][upd_way_i];
  assign same_entry = evict_valid_i && (evict_set_i == upd_set_i) && (evict_way_i == upd_way_i);

  // no reset: a line's count is defined by its first fill
  always_ff @(posedge clk_i) begin
    if (evict_valid_i) cnt_q[evict_set_i][evict_way_i] <= '0;
    if (upd_valid_i) begin
      if (same_entry)             cnt_q[upd_set_i][upd_way_i] <= CNT_W'(1);
      else if (cur_cnt != CNT_MAX) cnt_q[upd_set_i][upd_way_i] <= cur_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) rd_vals_o[w] = cnt_q[rd_set_i][w];
  end

  assert_lfu_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !(upd_valid_i && same_entry))
      |=> cnt_q[$past(evict_set_i)][$past(evict_way_i)] == '0);
  assert_lfu_refill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && same_entry) |=> cnt_q[$past(upd_set_i)][$past(upd_way_i)] == CNT_W'(1));
  assert_lfu_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !same_entry && cur_cnt != CNT_MAX)
      |=> cnt_q[$past(upd_set_i)][$past(upd_way_i)] == $past(cur_cnt) + CNT_W'(1));
  assert_lfu_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !same_entry && cur_cnt == CNT_MAX)
      |=> cnt_q[$past(upd_set_i)][$past(upd_way_i)] == CNT_MAX);
endmodule

// File: rtl/repl_lru_array.sv
module repl_lru_array #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int STAMP_W  = 32,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               upd_valid_i,
  input  logic [SET_W-1:0]                   upd_set_i,
  input  logic [WAY_W-1:0]                   upd_way_i,
  input  logic [STAMP_W-1:0]                 stamp_i,
  input  logic [SET_W-1:0]                   rd_set_i,
  output logic [NUM_WAYS-1:0][STAMP_W-1:0]   rd_vals_o
);
  logic [STAMP_W-1:0] stamp_q [NUM_SETS][NUM_WAYS];

  always_ff @(posedge clk_i) begin
    if (upd_valid_i) stamp_q[upd_set_i][upd_way_i] <= stamp_i;
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) rd_vals_o[w] = stamp_q[rd_set_i][w];
  end

  assert_lru_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> stamp_q[$past(upd_set_i)][$past(upd_way_i)] == $past(stamp_i));
endmodule

// File: rtl/repl_min_scan.sv
module repl_min_scan #(
  parameter int NUM_WAYS = 4,
  parameter int VAL_W    = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WAYS-1:0][VAL_W-1:0] vals_i,
  output logic [WAY_W-1:0]               idx_o
);
  logic [VAL_W-1:0] best_val;

  // strict compare keeps the lowest index on ties
  always_comb begin
    idx_o    = '0;
    best_val = vals_i[0];
    for (int i = 1; i < NUM_WAYS; i++) begin
      if (vals_i[i] < best_val) begin
        best_val = vals_i[i];
        idx_o    = WAY_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chk
    assert_min_not_above_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vals_i[g] >= vals_i[idx_o]);
    assert_tie_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (WAY_W'(g) < idx_o) |-> (vals_i[g] > vals_i[idx_o]));
  end
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
  import repl_pkg::*;
#(
  parameter int           NUM_SETS = 8,
  parameter int           NUM_WAYS = 4,
  parameter repl_policy_e POLICY   = REPL_LFU,
  parameter int           CNT_W    = 4,
  parameter int           STAMP_W  = 32,
  parameter int           LFSR_W   = 16,
  parameter logic [15:0]  TAPS     = 16'hB400,
  parameter logic [15:0]  SEED     = 16'hACE1,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic             evict_valid_i,
  input  logic [SET_W-1:0] evict_set_i,
  input  logic [WAY_W-1:0] evict_way_i,
  input  logic             req_valid_i,
  input  logic [SET_W-1:0] req_set_i,
  output logic             victim_valid_o,
  output logic [WAY_W-1:0] victim_way_o
);
  localparam int VAL_W = (POLICY == REPL_LRU) ? STAMP_W : CNT_W;

  logic [WAY_W-1:0] pick_way;
  logic             valid_q;
  logic [WAY_W-1:0] way_q;

  if (NUM_WAYS < 2 || LFSR_W < WAY_W || LFSR_W > 16) begin : g_bad_cfg
    $error("repl_victim_sel: unsupported way count or random width");
  end

  if (POLICY == REPL_RANDOM) begin : g_rand
    logic [LFSR_W-1:0] lfsr_val;
    repl_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .advance_i(req_valid_i),
      .state_o  (lfsr_val)
    );
    assign pick_way = WAY_W'(lfsr_val % LFSR_W'(NUM_WAYS));
  end else begin : g_scan
    logic [NUM_WAYS-1:0][VAL_W-1:0] set_vals;

    if (POLICY == REPL_LRU) begin : g_lru
      logic [STAMP_W-1:0] now_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      now_q <= '0;
        else if (~&now_q) now_q <= now_q + STAMP_W'(1);
      end
      repl_lru_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .STAMP_W(STAMP_W)) u_arr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .upd_valid_i(upd_valid_i),
        .upd_set_i  (upd_set_i),
        .upd_way_i  (upd_way_i),
        .stamp_i    (now_q),
        .rd_set_i   (req_set_i),
        .rd_vals_o  (set_vals)
      );
      assert_stamp_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> now_q >= $past(now_q));
    end else begin : g_lfu
      repl_lfu_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) u_arr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_valid_i  (upd_valid_i),
        .upd_set_i    (upd_set_i),
        .upd_way_i    (upd_way_i),
        .evict_valid_i(evict_valid_i),
        .evict_set_i  (evict_set_i),
        .evict_way_i  (evict_way_i),
        .rd_set_i     (req_set_i),
        .rd_vals_o    (set_vals)
      );
    end

    repl_min_scan #(.NUM_WAYS(NUM_WAYS), .VAL_W(VAL_W)) u_scan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vals_i(set_vals),
      .idx_o (pick_way)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      way_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) way_q <= pick_way;
    end
  end

  assign victim_valid_o = valid_q;
  assign victim_way_o   = way_q;

  assert_valid_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> victim_valid_o);
  assert_no_spurious_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !victim_valid_o);
  assert_way_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (int'(victim_way_o) < NUM_WAYS));
  assert_req_known_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !$isunknown(req_set_i));
  assert_upd_known_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |-> !$isunknown({upd_set_i, upd_way_i}));
  assert_evict_known_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i |-> !$isunknown({evict_set_i, evict_way_i}));
endmodule

// File: tb/repl_victim_sel_test.sv
module repl_victim_sel_test;
  import repl_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          SETS       = 8;
  localparam int          WAYS       = 4;
  localparam int          CNT_W      = 4;
  localparam int          CNT_MAX    = (1 << CNT_W) - 1;
  localparam logic [15:0] SEED       = 16'hACE1;
  localparam int          SET_W      = $clog2(SETS);
  localparam int          WAY_W      = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             upd_valid = 1'b0, evict_valid = 1'b0, req_valid = 1'b0;
  logic [SET_W-1:0] upd_set = '0, evict_set = '0, req_set = '0;
  logic [WAY_W-1:0] upd_way = '0, evict_way = '0;
  logic             v_lfu, v_lru, v_rnd;
  logic [WAY_W-1:0] w_lfu, w_lru, w_rnd;

  int          lfu_m [SETS][WAYS];
  longint      lru_m [SETS][WAYS];
  longint      now_m;
  logic [15:0] lfsr_m;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(REPL_LFU), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_valid_i(upd_valid), .upd_set_i(upd_set), .upd_way_i(upd_way),
    .evict_valid_i(evict_valid), .evict_set_i(evict_set), .evict_way_i(evict_way),
    .req_valid_i(req_valid), .req_set_i(req_set),
    .victim_valid_o(v_lfu), .victim_way_o(w_lfu));

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(REPL_LRU)) uut_lru (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_valid_i(upd_valid), .upd_set_i(upd_set), .upd_way_i(upd_way),
    .evict_valid_i(evict_valid), .evict_set_i(evict_set), .evict_way_i(evict_way),
    .req_valid_i(req_valid), .req_set_i(req_set),
    .victim_valid_o(v_lru), .victim_way_o(w_lru));

  repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(REPL_RANDOM), .SEED(SEED)) uut_rnd (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_valid_i(upd_valid), .upd_set_i(upd_set), .upd_way_i(upd_way),
    .evict_valid_i(evict_valid), .evict_set_i(evict_set), .evict_way_i(evict_way),
    .req_valid_i(req_valid), .req_set_i(req_set),
    .victim_valid_o(v_rnd), .victim_way_o(w_rnd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min_lfu(input int s);
    int best = 0;
    for (int w = 1; w < WAYS; w++) if (lfu_m[s][w] < lfu_m[s][best]) best = w;
    return best;
  endfunction

  function automatic int min_lru(input int s);
    int best = 0;
    for (int w = 1; w < WAYS; w++) if (lru_m[s][w] < lru_m[s][best]) best = w;
    return best;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // one clock: drive at falling edge, result sampled one falling edge later
  task automatic step(input bit u, input int us, input int uw,
                      input bit e, input int es, input int ew,
                      input bit r, input int rs, input string tag);
    int e_lfu, e_lru, e_rnd;
    upd_valid = u;   upd_set = SET_W'(us);   upd_way = WAY_W'(uw);
    evict_valid = e; evict_set = SET_W'(es); evict_way = WAY_W'(ew);
    req_valid = r;   req_set = SET_W'(rs);
    e_lfu = min_lfu(rs);
    e_lru = min_lru(rs);
    e_rnd = int'(lfsr_m % 16'(WAYS));
    if (e) lfu_m[es][ew] = 0;
    if (u) begin
      if (e && es == us && ew == uw) lfu_m[us][uw] = 1;
      else if (lfu_m[us][uw] < CNT_MAX) lfu_m[us][uw]++;
      lru_m[us][uw] = now_m;
    end
    now_m++;
    if (r) lfsr_m = lfsr_next(lfsr_m);
    @(posedge clk);
    @(negedge clk);
    check(v_lfu == r, "R1 lfu valid", int'(v_lfu), int'(r));
    check(v_lru == r, "R1 lru valid", int'(v_lru), int'(r));
    check(v_rnd == r, "R1 rnd valid", int'(v_rnd), int'(r));
    if (r) begin
      check(int'(w_lfu) == e_lfu, {tag, " lfu way"}, int'(w_lfu), e_lfu);
      check(int'(w_lru) == e_lru, {tag, " lru way"}, int'(w_lru), e_lru);
      check(int'(w_rnd) == e_rnd, "R7 rnd way", int'(w_rnd), e_rnd);
    end
  endtask

  task automatic do_reset();
    upd_valid = 0; evict_valid = 0; req_valid = 0;
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    now_m  = 0;
    lfsr_m = SEED;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(7);
    @(negedge clk);
    do_reset();
    // R1: outputs idle after reset
    check(v_lfu == 0 && v_lru == 0 && v_rnd == 0, "R1 reset valid", int'(v_lfu | v_lru | v_rnd), 0);
    check(w_lfu == 0 && w_rnd == 0, "R1 reset way", int'(w_lfu) + int'(w_rnd), 0);

    // fill every entry: access plus eviction in one cycle (R4 leaves 1)
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        step(1, s, w, 1, s, w, 0, 0, "init");

    step(0, 0, 0, 0, 0, 0, 1, 0, "R6 tie");          // LFU tie -> way 0, LRU oldest -> 0
    step(0, 0, 0, 1, 3, 2, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 3, "R4 cleared");      // way 2 count 0
    check(w_lfu == 2, "R4 cleared way", int'(w_lfu), 2);

    // R3 saturation in set 2
    for (int i = 0; i < 20; i++) step(1, 2, 0, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 14; i++) step(1, 2, 1, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 14; i++) step(1, 2, 2, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 13; i++) step(1, 2, 3, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 2, "R3 sat");
    check(w_lfu == 3, "R3 saturated", int'(w_lfu), 3);

    // R2: same-cycle access not visible to the concurrent request
    step(1, 5, 0, 0, 0, 0, 1, 5, "R2");
    check(w_lfu == 0 && w_lru == 0, "R2 pre-update", int'(w_lfu) + int'(w_lru), 0);
    step(0, 0, 0, 0, 0, 0, 1, 5, "R2 after");
    check(w_lfu == 1 && w_lru == 1, "R2 post-update", int'(w_lfu) + int'(w_lru), 2);

    // R5: eviction does not touch LRU stamps
    step(1, 6, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 6, 1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 1, 6, "R5 evict ignored");
    check(w_lru == 1, "R5 evict ignored", int'(w_lru), 1);

    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1), $urandom_range(0, SETS-1), $urandom_range(0, WAYS-1),
           ($urandom_range(0, 3) == 0), $urandom_range(0, SETS-1), $urandom_range(0, WAYS-1),
           ($urandom_range(0, 4) < 2), $urandom_range(0, SETS-1), "R6 R5 R3");

    // R8: state survives reset; stamp and random restart
    do_reset();
    check(v_lfu == 0 && v_lru == 0 && v_rnd == 0, "R8 valid after reset", int'(v_lfu | v_lru | v_rnd), 0);
    for (int s = 0; s < SETS; s++) step(0, 0, 0, 0, 0, 0, 1, s, "R8 kept");

    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 1), $urandom_range(0, SETS-1), $urandom_range(0, WAYS-1),
           ($urandom_range(0, 3) == 0), $urandom_range(0, SETS-1), $urandom_range(0, WAYS-1),
           ($urandom_range(0, 4) < 2), $urandom_range(0, SETS-1), "R6");

    done = 1;
    finish_run();
  end
endmodule